// File: doc/BRIEF.md
# Destination Descriptor Completion Writer

This block closes out each request of a crypto engine on the output side. The engine uses one destination descriptor per request. The descriptors lie in a ring in memory, and the ring starts at a base address that is programmed separately. When the engine signals that a request has finished, the block first reads the mode word of the current descriptor. If software has not handed that descriptor to the engine, the block raises a missing-descriptor flag and does nothing else. Otherwise it writes the 160-bit digest into the descriptor's inline result area, but only if the request involved hashing. Its last write is the mode word, with the ownership bit cleared. The pointer then moves to the next descriptor, or back to the base when the descriptor is marked as end of ring.

Requests arrive over a valid/ready handshake. A request is taken only when both `req_valid` and `req_ready` are high on a clock edge. The requester must hold `req_valid`, `req_hash` and `req_digest` steady while `req_ready` is low, which is the case whenever a request is in progress. Memory accesses leave on a word-wide valid/ready port, and read data returns later on `mem_rvalid`. The pending flags, their enables and a software reset are plain control pins.

Descriptor layout, in bytes from the descriptor address: the mode word at 0, the output buffer address at 4, an unused word at 8, and digest words 0 to 4 at 12 to 28. Each descriptor takes 32 bytes.

Top module: `dd_compl_writer`

## Requirements
- R1: `req_ready` is high only while the block is idle and `sw_rst` is low. A request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after an acceptance.
- R2: The first memory access after an acceptance is a read (`mem_we` = 0) of the mode word at the current descriptor address.
- R3: If the mode word has bit 31 set and `req_hash` was 1, digest word k is written to address descriptor + 12 + 4·k, for k = 0 to 4. Digest word k is `req_digest[159-32k -: 32]`.
- R4: If the mode word has bit 31 set and `req_hash` was 0, the only write is the mode word, and the digest area is left unchanged.
- R5: The mode word is written back with bit 31 cleared and all other bits kept as read. This is always the last write of the request, after every digest write.
- R6: After the mode-word write, the pointer advances by 32 bytes. If bit 30 of the mode word was set, the pointer returns to `cfg_ring_base` instead.
- R7: If the mode word has bit 31 clear, the block makes no write, leaves the pointer unchanged and sets `pend[1]`.
- R8: A completed request sets `pend[0]`. A 1 on bit i of `pend_clr` clears `pend[i]`. `irq` is high exactly when some pending bit has its `cfg_irq_en` bit set.
- R9: `sw_rst` reloads the pointer from `cfg_ring_base`, clears both pending bits and abandons any request in progress.
- R10: After reset `req_ready` is 1, `mem_req_valid` is 0, `pend` is 0 and `irq` is 0. The pointer holds `cfg_ring_base`.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid, and `mem_we`, `mem_addr` and `mem_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset pulse |
| cfg_ring_base | input | 32 | Byte address of the first descriptor of the ring |
| cfg_irq_en | input | 2 | Interrupt enables: bit 0 for completion, bit 1 for missing descriptor |
| pend_clr | input | 2 | Write-one clear for the pending bits |
| req_valid | input | 1 | Request-done strobe |
| req_ready | output | 1 | Block can accept a request |
| req_hash | input | 1 | The request included hashing |
| req_digest | input | 160 | Digest result, word 0 in the top bits |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pend | output | 2 | Pending bits: bit 0 completion, bit 1 missing descriptor |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. The memory returns exactly one `mem_rvalid` for each read it accepts, and never one without an accepted read. `sw_rst` and `pend_clr` are single pulses. Requesters keep `req_valid` and its data steady until they are accepted. The bench memory model drives `mem_rvalid` only for the read it accepted, after a random delay of one or two cycles. It holds the request fields until acceptance and pulses each control for one cycle. `mem_req_ready` is drawn at random every cycle, so the stall path is exercised at random points.

// File: rtl/dd_pkg.sv
package dd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_VEC,
    ST_WR_OWN
  } dd_state_e;

  localparam int WORD_W    = 32;
  localparam int OWN_BIT   = 31;
  localparam int EOR_BIT   = 30;
  localparam int HDR_WORDS = 3;  // mode, buffer address, unused
endpackage

// File: rtl/dd_ptr.sv
module dd_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      ptr <= base;
    end else if (adv) begin
      ptr <= wrap ? base : ptr + AW'(DESC_BYTES);
    end
  end
endmodule

// File: rtl/dd_pend.sv
module dd_pend #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_rst,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] ie,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      pend <= '0;
    end else begin
      pend <= (pend & ~clr) | set;
    end
  end

  assign irq = |(pend & ie);
endmodule

// File: rtl/dd_seq.sv
module dd_seq
  import dd_pkg::*;
#(
  parameter  int AW        = 32,
  parameter  int VEC_WORDS = 5,
  localparam int DIG_W     = VEC_WORDS * WORD_W,
  localparam int IW        = (VEC_WORDS > 1) ? $clog2(VEC_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_hash,
  input  logic [DIG_W-1:0]  req_digest,
  input  logic [AW-1:0]     ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              adv,
  output logic              wrap,
  output logic              done_ok,
  output logic              done_miss
);
  dd_state_e          st_q, st_d;
  logic               hash_q;
  logic [DIG_W-1:0]   dig_q;
  logic [WORD_W-1:0]  mode_q;
  logic [IW-1:0]      vidx_q;
  logic [WORD_W-1:0]  vec_w [VEC_WORDS];
  logic               last_vec;

  for (genvar g = 0; g < VEC_WORDS; g++) begin : g_vec
    assign vec_w[g] = dig_q[DIG_W-1-WORD_W*g -: WORD_W];
  end

  assign req_ready = (st_q == ST_IDLE) && !sw_rst;
  assign last_vec  = (vidx_q == IW'(VEC_WORDS - 1));
  assign wrap      = mode_q[EOR_BIT];

  always_comb begin
    st_d          = st_q;
    mem_req_valid = 1'b0;
    mem_we        = 1'b0;
    mem_addr      = ptr;
    mem_wdata     = '0;
    adv           = 1'b0;
    done_ok       = 1'b0;
    done_miss     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid && req_ready) st_d = ST_RD_REQ;
      end
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rvalid) begin
          if (!mem_rdata[OWN_BIT]) begin
            done_miss = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            st_d = hash_q ? ST_WR_VEC : ST_WR_OWN;
          end
        end
      end
      ST_WR_VEC: begin
        mem_req_valid = 1'b1;
        mem_we        = 1'b1;
        mem_addr      = ptr + AW'(HDR_WORDS * 4) + (AW'(vidx_q) << 2);
        mem_wdata     = vec_w[vidx_q];
        if (mem_req_ready && last_vec) st_d = ST_WR_OWN;
      end
      ST_WR_OWN: begin
        mem_req_valid = 1'b1;
        mem_we        = 1'b1;
        mem_wdata     = mode_q & ~(WORD_W'(1) << OWN_BIT);
        if (mem_req_ready) begin
          adv     = 1'b1;
          done_ok = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      st_q   <= ST_IDLE;
      hash_q <= 1'b0;
      dig_q  <= '0;
      mode_q <= '0;
      vidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid && req_ready) begin
        hash_q <= req_hash;
        dig_q  <= req_digest;
      end
      if (st_q == ST_RD_WAIT && mem_rvalid) begin
        mode_q <= mem_rdata;
        vidx_q <= '0;
      end
      if (st_q == ST_WR_VEC && mem_req_ready && !last_vec) begin
        vidx_q <= vidx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dd_compl_writer.sv
module dd_compl_writer
  import dd_pkg::*;
#(
  parameter  int AW        = 32,
  parameter  int VEC_WORDS = 5,
  localparam int DIG_W     = VEC_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [AW-1:0]     cfg_ring_base,
  input  logic [1:0]        cfg_irq_en,
  input  logic [1:0]        pend_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_hash,
  input  logic [DIG_W-1:0]  req_digest,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [1:0]        pend,
  output logic              irq
);
  localparam int DESC_WORDS = HDR_WORDS + VEC_WORDS;
  localparam int DESC_BYTES = DESC_WORDS * 4;

  logic [AW-1:0] ptr;
  logic          adv, wrap, done_ok, done_miss;

  dd_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .base(cfg_ring_base),
    .adv(adv), .wrap(wrap), .ptr(ptr)
  );

  dd_seq #(.AW(AW), .VEC_WORDS(VEC_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_hash(req_hash),
    .req_digest(req_digest), .ptr(ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .adv(adv), .wrap(wrap), .done_ok(done_ok), .done_miss(done_miss)
  );

  dd_pend #(.NSRC(2)) u_pend (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .set({done_miss, done_ok}), .clr(pend_clr), .ie(cfg_irq_en),
    .pend(pend), .irq(irq)
  );
endmodule

// File: rtl/dd_compl_writer_chk.sv
module dd_compl_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [1:0]    pend,
  input logic          irq
);
  // R11: a stalled memory request keeps its fields
  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R1: no second acceptance right after one
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2: a request starts with a read
  a_r2_read_first: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    req_valid && req_ready |=> mem_req_valid && !mem_we);

  // R9: software reset empties the pending bits
  a_r9_clear_pend: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> pend == 2'b00);

  // R8: an interrupt always has a pending cause
  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend != 2'b00);

  // R1: no memory traffic while the block offers to accept a request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    req_ready |-> !mem_req_valid);
endmodule

bind dd_compl_writer dd_compl_writer_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_dd_compl_writer.sv
`timescale 1ns/1ps
module test_dd_compl_writer;
  localparam logic [31:0] BASE  = 32'h40;
  localparam int          NDESC = 4;
  localparam int          MEMW  = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sw_rst = 1'b0;
  logic [31:0]  cfg_ring_base = BASE;
  logic [1:0]   cfg_irq_en = 2'b00;
  logic [1:0]   pend_clr = 2'b00;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_hash = 1'b0;
  logic [159:0] req_digest = '0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic         mem_rvalid = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic [1:0]   pend;
  logic         irq;

  always #5 clk = ~clk;

  dd_compl_writer i_dd_compl_writer (.*);

  logic [31:0] mem     [MEMW];
  logic [31:0] exp_mem [MEMW];
  logic [31:0] exp_ptr;
  logic [1:0]  exp_pend;
  int          ready_pct = 70;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  int          n_tx, wr_cnt, rd_cnt;
  logic [31:0] first_addr, last_wr_addr, rd_data;
  logic        first_we;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] dig_word(logic [159:0] d, int k);
    return d[159 - 32*k -: 32];
  endfunction

  // memory model
  initial begin
    rd_cnt = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd_data;
        end
      end
      mem_req_ready = ($urandom_range(99) < ready_pct);
      if (rst_n && mem_req_valid === 1'b1 && mem_req_ready) begin
        if (n_tx == 0) begin
          first_addr = mem_addr;
          first_we   = mem_we;
        end
        n_tx++;
        if (mem_we) begin
          mem[mem_addr[7:2]] = mem_wdata;
          wr_cnt++;
          last_wr_addr = mem_addr;
        end else begin
          rd_data = mem[mem_addr[7:2]];
          rd_cnt  = 1 + $urandom_range(1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic arm(bit owned);
    int idx = exp_ptr[7:2];
    int slot = (exp_ptr - BASE) / 32;
    logic [31:0] m = {owned, (slot == NDESC - 1), 30'($urandom)};
    mem[idx] = m;
    exp_mem[idx] = m;
  endtask

  task automatic do_req(bit hash, logic [159:0] dig, string tag);
    int idx = exp_ptr[7:2];
    logic [31:0] m = exp_mem[idx];
    logic [31:0] old_ptr = exp_ptr;
    int wr_exp;
    n_tx = 0; wr_cnt = 0;
    if (!m[31]) begin
      exp_pend[1] = 1'b1;
      wr_exp = 0;
    end else begin
      if (hash) for (int k = 0; k < 5; k++) exp_mem[idx + 3 + k] = dig_word(dig, k);
      exp_mem[idx] = m & 32'h7fff_ffff;
      exp_pend[0] = 1'b1;
      wr_exp = hash ? 6 : 1;
      exp_ptr = m[30] ? BASE : exp_ptr + 32;
    end
    @(negedge clk);
    req_valid = 1'b1; req_hash = hash; req_digest = dig;
    forever begin
      automatic logic was = req_ready;
      @(negedge clk);
      if (was) break;
    end
    chk({"R1 busy after accept ", tag}, {31'b0, req_ready}, 32'd0);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk({"R2 first access addr ", tag}, first_addr, old_ptr);
    chk({"R2 first access is read ", tag}, {31'b0, first_we}, 32'd0);
    if (wr_exp == 0) chk({"R7 no writes on miss ", tag}, wr_cnt, 0);
    else if (hash) chk({"R3 write count with hash ", tag}, wr_cnt, 6);
    else chk({"R4 write count without hash ", tag}, wr_cnt, 1);
    if (wr_exp != 0) chk({"R5 ownership write last ", tag}, last_wr_addr, old_ptr);
    for (int i = 0; i < MEMW; i++)
      if (mem[i] !== exp_mem[i]) begin
        chk({"R3/R5 memory image ", tag}, mem[i], exp_mem[i]);
        break;
      end
    chk({"R8 pending ", tag}, {30'b0, pend}, {30'b0, exp_pend});
    chk({"R8 irq ", tag}, {31'b0, irq}, {31'b0, |(exp_pend & cfg_irq_en)});
  endtask

  task automatic clear_pend(logic [1:0] c);
    @(negedge clk);
    pend_clr = c;
    @(negedge clk);
    pend_clr = 2'b00;
    exp_pend = exp_pend & ~c;
    chk("R8 pending after clear", {30'b0, pend}, {30'b0, exp_pend});
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMW; i++) begin
      mem[i] = $urandom;
      exp_mem[i] = mem[i];
    end
    exp_ptr = BASE; exp_pend = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R10 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R10 pend", {30'b0, pend}, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'd0);

    // directed: hash, no hash, miss, wrap through the ring
    cfg_irq_en = 2'b01;
    arm(1); do_req(1, {5{32'hA5A5_0F0F}} ^ 160'h1234, "R3 directed hash");
    arm(1); do_req(0, '1, "R4 directed no hash");
    arm(0); do_req(1, '1, "R7 directed miss");
    chk("R7 irq masked miss", {31'b0, irq}, 32'd1);
    clear_pend(2'b01);
    cfg_irq_en = 2'b10;
    @(negedge clk);
    chk("R8 irq from miss only", {31'b0, irq}, 32'd1);
    clear_pend(2'b10);
    arm(1); do_req(1, {160{1'b1}}, "R6 before wrap");
    arm(1); do_req(0, '0, "R6 wrap slot");
    chk("R6 pointer back at base", exp_ptr, BASE);
    arm(1); do_req(1, 160'h0123_4567_89ab_cdef, "R6 after wrap");

    // R9 software reset
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    exp_pend = 2'b00; exp_ptr = BASE;
    chk("R9 pend after sw_rst", {30'b0, pend}, 32'd0);
    arm(1); do_req(1, 160'hfeed, "R9 restart at base");

    // random phase
    for (int n = 0; n < 60; n++) begin
      automatic logic [159:0] d = {$urandom, $urandom, $urandom, $urandom, $urandom};
      ready_pct = 30 + $urandom_range(70);
      cfg_irq_en = 2'($urandom);
      arm($urandom_range(5) != 0);
      do_req($urandom_range(1), d, "random");
      if ($urandom_range(2) == 0) clear_pend(2'($urandom));
    end
    summary();
  end
endmodule